// File: doc/BRIEF.md
# Sequenced Register Command Engine

This block turns a stream of two-word register commands into single-cycle accesses on a simple internal register bus. For every command it returns a two-word acknowledgement that carries the command's sequence number back to the requester. A command is made of a control word and a data word. The control word holds a register index, a write flag and a 16-bit sequence number. The data word is the write value, or a don't-care for reads.

Each command may also carry a timestamp. A timed command is held at the head of the queue until a free-running device time input reaches its timestamp value. Commands are buffered on entry so that a requester may keep fifteen or more commands in flight. Commands run strictly one after another, in arrival order. Acknowledgements leave on a valid/ready stream that may apply back-pressure at any time.

Top module: `seq_cmd_engine`

## Requirements
- R1: A command is two accepted beats on the input stream: the control word first, then the data word. The timestamp flag and time value are taken with the control word. In the control word, bits [7:0] are the register index, bit 8 = 1 selects a write, and bits [31:16] are the sequence number.
- R2: A write command performs exactly one one-cycle bus write of the data word to the indexed register.
- R3: A read command performs a bus read and returns the register's value as the second acknowledgement word. Its data word is ignored, and the register keeps its value.
- R4: Acknowledgement word 0 carries the command's sequence number in bits [31:16], including the values 16'hFFFF and 16'h0000 across the wrap. ack_last is 0 on word 0 and 1 on word 1.
- R5: Commands execute, and are acknowledged, in arrival order. A new acknowledgement is never loaded while the previous one is still pending.
- R6: The input buffer holds 16 commands. With the acknowledgement output stalled, 17 back-to-back commands are accepted without stalling, and in_ready then drops to 0.
- R7: A command with its timestamp flag set makes no bus access and sends no acknowledgement while dev_time is below its timestamp. It executes once dev_time >= timestamp.
- R8: A waiting timed command blocks every later command, including untimed ones.
- R9: While ack_valid = 1 and ack_ready = 0, ack_valid, ack_word and ack_last hold steady. No acknowledgement is dropped.
- R10: An untimed command executes without regard to its time field. Its acknowledgement appears within six cycles of the data beat being accepted.
- R11: After reset, in_ready = 1, ack_valid = 0 and bus_en = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| in_word | input | 32 | Control word or data word |
| in_timed | input | 1 | Timestamp flag, taken with the control word |
| in_time | input | 64 | Timestamp, taken with the control word |
| dev_time | input | 64 | Free-running device time |
| bus_en | output | 1 | Register access strobe, one cycle |
| bus_we | output | 1 | Write select for the access |
| bus_addr | output | 8 | Register index |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, registered by the slave one cycle after bus_en |
| ack_valid | output | 1 | Acknowledgement word valid |
| ack_ready | input | 1 | Acknowledgement consumer ready |
| ack_word | output | 32 | Acknowledgement word |
| ack_last | output | 1 | Marks the second acknowledgement word |

## Verification
The assertions rely on three properties of the inputs. The register slave returns read data exactly one cycle after a strobe. dev_time only increases and never wraps, so a timed command released at one point stays eligible when its strobe is issued. Requesters never push more than the buffer can hold. The bench keeps to these rules. Its slave model registers read data on the strobe edge, and its time counter increments once per clock from reset. Each command is driven only while in_ready is high, so the stalled-output fill test stops at the buffer limit.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
  localparam int WORD_W = 32;
  localparam int SEQ_W  = 16;
  localparam int IDX_W  = 8;
  localparam int TIME_W = 64;
  localparam int WR_BIT = 8;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] data;
    logic              timed;
    logic [TIME_W-1:0] ts;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef enum logic [1:0] {
    EX_IDLE    = 2'd0,
    EX_ACCESS  = 2'd1,
    EX_CAPTURE = 2'd2
  } ex_state_e;
endpackage

// File: rtl/seq_cmd_fifo.sv
module seq_cmd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [AW:0]   count, count_nx;

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    if (push) wr_ptr_nx = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_ptr_nx = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    case ({push, pop})
      2'b10:   count_nx = count + 1'b1;
      2'b01:   count_nx = count - 1'b1;
      default: count_nx = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R6
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
endmodule

// File: rtl/seq_cmd_exec.sv
module seq_cmd_exec
  import seq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              head,
  input  logic              empty,
  input  logic              ack_busy,
  input  logic [TIME_W-1:0] dev_time,
  output logic              pop,
  output logic              bus_en,
  output logic              bus_we,
  output logic [IDX_W-1:0]  bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              ack_load,
  output logic [WORD_W-1:0] ack_w0,
  output logic [WORD_W-1:0] ack_w1
);
  ex_state_e         state, state_nx;
  logic [WORD_W-1:0] cur_ctrl, cur_data;
  logic              cur_timed;
  logic [TIME_W-1:0] cur_ts;
  logic              released;

  assign released = !head.timed || (dev_time >= head.ts);

  always_comb begin
    state_nx = state;
    pop      = 1'b0;
    ack_load = 1'b0;
    case (state)
      EX_IDLE: begin
        if (!empty && !ack_busy && released) begin
          pop      = 1'b1;
          state_nx = EX_ACCESS;
        end
      end
      EX_ACCESS:  state_nx = EX_CAPTURE;
      EX_CAPTURE: begin
        ack_load = 1'b1;
        state_nx = EX_IDLE;
      end
      default: state_nx = EX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= EX_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ctrl  <= '0;
      cur_data  <= '0;
      cur_timed <= 1'b0;
      cur_ts    <= '0;
    end else if (pop) begin
      cur_ctrl  <= head.ctrl;
      cur_data  <= head.data;
      cur_timed <= head.timed;
      cur_ts    <= head.ts;
    end
  end

  assign bus_en    = (state == EX_ACCESS);
  assign bus_we    = cur_ctrl[WR_BIT];
  assign bus_addr  = cur_ctrl[IDX_W-1:0];
  assign bus_wdata = cur_data;
  assign ack_w0    = cur_ctrl;
  assign ack_w1    = cur_ctrl[WR_BIT] ? '0 : bus_rdata;

  AST_TIMED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && cur_timed) |-> (dev_time >= cur_ts)); // R7
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> !bus_en); // R2
  AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> ack_load); // R5
endmodule

// File: rtl/seq_ack_out.sv
module seq_ack_out
  import seq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] w0_in,
  input  logic [WORD_W-1:0] w1_in,
  output logic              busy,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [WORD_W-1:0] ack_word,
  output logic              ack_last
);
  logic              valid_q, valid_nx, phase_q, phase_nx;
  logic [WORD_W-1:0] w0_q, w1_q;

  always_comb begin
    valid_nx = valid_q;
    phase_nx = phase_q;
    if (load) begin
      valid_nx = 1'b1;
      phase_nx = 1'b0;
    end else if (valid_q && ack_ready) begin
      if (!phase_q) phase_nx = 1'b1;
      else          valid_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      valid_q <= valid_nx;
      phase_q <= phase_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
    end else if (load) begin
      w0_q <= w0_in;
      w1_q <= w1_in;
    end
  end

  assign busy      = valid_q;
  assign ack_valid = valid_q;
  assign ack_last  = phase_q;
  assign ack_word  = phase_q ? w1_q : w0_q;

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_word) && $stable(ack_last))); // R9
  AST_NO_ACK_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q); // R5
endmodule

// File: rtl/seq_cmd_engine.sv
module seq_cmd_engine
  import seq_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  input  logic                in_timed,
  input  logic [TIME_W-1:0]   in_time,
  input  logic [TIME_W-1:0]   dev_time,
  output logic                bus_en,
  output logic                bus_we,
  output logic [IDX_W-1:0]    bus_addr,
  output logic [WORD_W-1:0]   bus_wdata,
  input  logic [WORD_W-1:0]   bus_rdata,
  output logic                ack_valid,
  input  logic                ack_ready,
  output logic [WORD_W-1:0]   ack_word,
  output logic                ack_last
);
  logic              beat_fire, second_beat, second_nx, push;
  logic [WORD_W-1:0] hold_ctrl;
  logic              hold_timed;
  logic [TIME_W-1:0] hold_ts;
  cmd_t              push_cmd, head;
  logic              fifo_full, fifo_empty, pop;
  logic              ack_busy, ack_load;
  logic [WORD_W-1:0] ack_w0, ack_w1;

  assign in_ready  = !fifo_full;
  assign beat_fire = in_valid && in_ready;
  assign push      = beat_fire && second_beat;
  assign second_nx = beat_fire ? !second_beat : second_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) second_beat <= 1'b0;
    else        second_beat <= second_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ctrl  <= '0;
      hold_timed <= 1'b0;
      hold_ts    <= '0;
    end else if (beat_fire && !second_beat) begin
      hold_ctrl  <= in_word;
      hold_timed <= in_timed;
      hold_ts    <= in_time;
    end
  end

  always_comb begin
    push_cmd.ctrl  = hold_ctrl;
    push_cmd.data  = in_word;
    push_cmd.timed = hold_timed;
    push_cmd.ts    = hold_ts;
  end

  seq_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_cmd),
    .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  seq_cmd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(fifo_empty),
    .ack_busy(ack_busy), .dev_time(dev_time), .pop(pop),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_load(ack_load), .ack_w0(ack_w0), .ack_w1(ack_w1)
  );

  seq_ack_out u_ack (
    .clk(clk), .rst_n(rst_n), .load(ack_load), .w0_in(ack_w0), .w1_in(ack_w1),
    .busy(ack_busy), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_word(ack_word), .ack_last(ack_last)
  );

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full); // R6
endmodule

// File: tb/sim_seq_cmd_engine.sv
`timescale 1ns/1ps
module sim_seq_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_timed;
  logic [31:0] in_word;
  logic [63:0] in_time, tnow;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ack_valid, ack_ready, ack_last;
  logic [31:0] ack_word;

  logic [31:0] regs [256];
  logic [63:0] wr_time [256];
  int total = 0, fails = 0, stalls = 0;

  always #2.5 clk = ~clk;

  seq_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_timed(in_timed), .in_time(in_time), .dev_time(tnow),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_word(ack_word), .ack_last(ack_last)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tnow <= 64'd0;
    else        tnow <= tnow + 64'd1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin regs[i] <= 32'd0; wr_time[i] <= 64'd0; end
      bus_rdata <= 32'd0;
    end else if (bus_en) begin
      if (bus_we) begin regs[bus_addr] <= bus_wdata; wr_time[bus_addr] <= tnow; end
      else bus_rdata <= regs[bus_addr];
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] seq, input logic wr, input logic [7:0] idx);
    return {seq, 7'd0, wr, idx};
  endfunction

  task automatic send(input logic [31:0] c, input logic [31:0] d, input logic tm, input logic [63:0] ts);
    in_valid = 1'b1; in_word = c; in_timed = tm; in_time = ts;
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
    in_word = d; in_timed = 1'b0; in_time = 64'd0;
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_ack(output logic [31:0] w0, output logic [31:0] w1);
    ack_ready = 1'b1;
    while (!ack_valid) @(negedge clk);
    w0 = ack_word;
    chk("R4 word0 last", {63'd0, ack_last}, 64'd0);
    @(negedge clk);
    while (!ack_valid) @(negedge clk);
    w1 = ack_word;
    chk("R4 word1 last", {63'd0, ack_last}, 64'd1);
    @(negedge clk);
    ack_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 in_ready", {63'd0, in_ready}, 64'd1);
    chk("R11 ack_valid", {63'd0, ack_valid}, 64'd0);
    chk("R11 bus_en", {63'd0, bus_en}, 64'd0);
  endtask

  task automatic t_write_read;
    logic [31:0] a0, a1;
    send(ctl(16'h0011, 1'b1, 8'd3), 32'hA5A5_1234, 1'b0, 64'd0);
    get_ack(a0, a1);
    chk("R4 write seq", {48'd0, a0[31:16]}, 64'h11);
    chk("R2 write data", {32'd0, regs[3]}, 64'hA5A5_1234);
    send(ctl(16'h0012, 1'b0, 8'd3), 32'hDEAD_BEEF, 1'b0, 64'd0);
    get_ack(a0, a1);
    chk("R4 read seq", {48'd0, a0[31:16]}, 64'h12);
    chk("R3 read data", {32'd0, a1}, 64'hA5A5_1234);
    chk("R3 register unchanged", {32'd0, regs[3]}, 64'hA5A5_1234);
    chk("R1 index field", {32'd0, regs[4]}, 64'd0);
  endtask

  task automatic t_seq_wrap;
    logic [31:0] a0, a1;
    send(ctl(16'hFFFF, 1'b0, 8'd3), 32'd0, 1'b0, 64'd0);
    get_ack(a0, a1);
    chk("R4 seq FFFF", {48'd0, a0[31:16]}, 64'hFFFF);
    send(ctl(16'h0000, 1'b1, 8'd7), 32'h0000_0077, 1'b0, 64'd0);
    get_ack(a0, a1);
    chk("R4 seq 0000", {48'd0, a0[31:16]}, 64'h0);
    chk("R1 write flag bit 8", {32'd0, regs[7]}, 64'h77);
  endtask

  task automatic t_depth_order;
    logic [31:0] a0, a1;
    stalls = 0;
    for (int i = 0; i < 17; i++)
      send(ctl(16'h0100 + 16'(i), 1'b1, 8'(20 + i)), 32'h1000 + 32'(i), 1'b0, 64'd0);
    chk("R6 no stall for 17 commands", 64'(stalls), 64'd0);
    chk("R6 in_ready low when full", {63'd0, in_ready}, 64'd0);
    for (int i = 0; i < 17; i++) begin
      get_ack(a0, a1);
      chk("R5 ack order", {48'd0, a0[31:16]}, 64'h0100 + 64'(i));
    end
    chk("R2 last queued write", {32'd0, regs[36]}, 64'h1010);
  endtask

  task automatic t_backpressure;
    logic [31:0] a0, a1, held;
    regs[9] = 32'hCAFE_0009;
    send(ctl(16'h0200, 1'b0, 8'd9), 32'd0, 1'b0, 64'd0);
    while (!ack_valid) @(negedge clk);
    held = ack_word;
    repeat (8) @(negedge clk);
    chk("R9 valid held", {63'd0, ack_valid}, 64'd1);
    chk("R9 word held", {32'd0, ack_word}, {32'd0, held});
    chk("R9 last held", {63'd0, ack_last}, 64'd0);
    get_ack(a0, a1);
    chk("R9 seq kept", {48'd0, a0[31:16]}, 64'h0200);
    chk("R9 data kept", {32'd0, a1}, 64'hCAFE_0009);
  endtask

  task automatic t_timed;
    logic [31:0] a0, a1;
    logic [63:0] ts;
    ts = tnow + 64'd60;
    send(ctl(16'h0300, 1'b1, 8'd5), 32'h5555, 1'b1, ts);
    send(ctl(16'h0301, 1'b1, 8'd6), 32'h6666, 1'b0, 64'd0);
    repeat (20) @(negedge clk);
    chk("R7 no ack before time", {63'd0, ack_valid}, 64'd0);
    chk("R7 no write before time", {32'd0, regs[5]}, 64'd0);
    chk("R8 later command blocked", {32'd0, regs[6]}, 64'd0);
    get_ack(a0, a1);
    chk("R7 timed seq", {48'd0, a0[31:16]}, 64'h0300);
    chk("R7 written at or after time", {63'd0, wr_time[5] >= ts}, 64'd1);
    get_ack(a0, a1);
    chk("R8 follower seq", {48'd0, a0[31:16]}, 64'h0301);
    chk("R8 follower after timed", {63'd0, wr_time[6] > wr_time[5]}, 64'd1);
  endtask

  task automatic t_untimed_ignores_time;
    logic [31:0] a0, a1;
    send(ctl(16'h0400, 1'b1, 8'd8), 32'h8888, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    repeat (5) @(negedge clk);
    chk("R10 ack ready in time", {63'd0, ack_valid}, 64'd1);
    get_ack(a0, a1);
    chk("R10 written", {32'd0, regs[8]}, 64'h8888);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_timed = 1'b0; in_time = '0; ack_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_seq_wrap();
    t_depth_order();
    t_backpressure();
    t_timed();
    t_untimed_ignores_time();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule